// File: doc/BRIEF.md
# Receive Line Status Tracker

This block holds the eight-bit line status word of a 16550-style serial port and the receive FIFO behind it. Every character that the receive shifter delivers is stored together with its own parity-error, framing-error and break flags, so an error stays attached to the character that caused it. The error flags appear in the status word when that character reaches the head of the FIFO.

A receive-buffer read pops the head character. A read of the status word clears the sticky error bits. A FIFO clear drops every stored character. The two transmit-empty bits come directly from the transmitter's status lines. Turning the serial line into bytes is done elsewhere.

Top module: `line_status_unit`

## Requirements
- R1: Status bit 0 (data ready) is 1 exactly when the level count is non-zero. The level count rises by one for each accepted push and falls by one for each pop of a non-empty FIFO. Every register change is visible on the cycle after the strobe.
- R2: Status bits 1 (overrun), 2 (parity), 3 (framing), 4 (break) and 7 (error summary) are sticky. They stay set after the character that set them is popped, and a status-read strobe clears them.
- R3: A break arrives as a zero byte with the break flag set. Pushed into an empty FIFO with the transmitter idle, it makes the status 0xF1.
- R4: A push while all 16 entries are held, with no pop in the same cycle, is dropped and sets overrun and bit 7 (status 0xE3 with transmit idle). The 16 stored bytes then read back in arrival order.
- R5: A pop while the FIFO is empty leaves the level at 0 and the status at 0x60 with transmit idle.
- R6: A FIFO clear empties the FIFO and clears bits 1 to 4 and bit 7. The status then reads 0x60 with transmit idle. A clear wins over a push or pop in the same cycle.
- R7: The parity, framing and break bits are loaded from an entry's flags in the cycle that entry becomes the head, and not before. A flagged entry behind a clean head sets only bit 7.
- R8: Bit 5 equals the transmit-holding-empty input. Bit 6 is 1 only when the holding-empty and shifter-idle inputs are both 1.
- R9: When a status read and a new error event fall in the same cycle, the new error is kept.
- R10: A push and a pop in the same cycle while the FIFO is full are both performed. The level stays at 16 and no overrun is raised.
- R11: headData shows the byte at the FIFO head, or 0 when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Receive shifter delivers a character |
| pushData | input | 8 | Received byte |
| pushParityErr | input | 1 | Parity error flag of the received byte |
| pushFrameErr | input | 1 | Framing error flag of the received byte |
| pushBreak | input | 1 | Byte represents a break condition |
| popStrobe | input | 1 | Receive-buffer read, pops the head |
| statusRead | input | 1 | Status-word read, clears sticky bits |
| fifoClear | input | 1 | Drops all stored characters |
| txHoldEmpty | input | 1 | Transmit holding register is empty |
| txShiftIdle | input | 1 | Transmit shifter is idle |
| statusByte | output | 8 | Line status word |
| headData | output | 8 | Byte at the FIFO head |
| fifoLevel | output | 5 | Number of stored characters |

## Verification
The hardest case to reach is an error flag that is hidden behind a clean head. The flagged entry must not touch bits 2 to 4 until the entry in front of it is popped, and it must then raise them even though a status read has already cleared bit 7. The stimulus builds this case by pushing a clean byte followed by a flagged byte. It then reads the status, pops once, and checks the bits at each step. A full FIFO is filled with sixteen pushes, and the bench then tests one extra push on its own and one extra push with a pop in the same cycle.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              parityErr;
    logic              frameErr;
    logic              brk;
  } rxEntry_t;

  typedef struct packed {
    logic doPush;
    logic doPop;
    logic doClear;
    logic doStatusRd;
    logic overrun;
  } lsrStrobe_t;
endpackage

// File: rtl/lsr_ctrl.sv
module lsr_ctrl
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            pushValid,
  input  logic            popStrobe,
  input  logic            statusRead,
  input  logic            fifoClear,
  input  logic [CNTW-1:0] level,
  output lsrStrobe_t      strobes
);
  localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

  logic popOk;
  logic spaceOk;

  always_comb begin
    popOk   = popStrobe && (level != '0) && !fifoClear;
    spaceOk = (level != FULL) || popOk;
    strobes.doClear    = fifoClear;
    strobes.doPop      = popOk;
    strobes.doPush     = pushValid && !fifoClear && spaceOk;
    strobes.overrun    = pushValid && !fifoClear && !spaceOk;
    strobes.doStatusRd = statusRead;
  end
endmodule

// File: rtl/lsr_datapath.sv
module lsr_datapath
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsrStrobe_t        strobes,
  input  rxEntry_t          inEntry,
  input  logic              txHoldEmpty,
  input  logic              txShiftIdle,
  output logic [CNTW-1:0]   level,
  output logic [7:0]        statusByte,
  output logic [DATA_W-1:0] headData
);
  localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

  rxEntry_t        mem [DEPTH];
  logic [PTRW-1:0] wrPtr, rdPtr, nextRd;
  logic            ovrSticky, peSticky, feSticky, biSticky, errSticky;

  rxEntry_t newHead;
  logic     headChange;
  logic     inErr, newHeadErr, anySet;

  always_comb begin
    nextRd     = rdPtr + 1'b1;
    inErr      = inEntry.parityErr | inEntry.frameErr | inEntry.brk;
    headChange = 1'b0;
    newHead    = '0;
    if (strobes.doPop && level > 1) begin
      headChange = 1'b1;
      newHead    = mem[nextRd];
    end else if (strobes.doPush && (level == '0 || strobes.doPop)) begin
      headChange = 1'b1;
      newHead    = inEntry;
    end
    newHeadErr = headChange & (newHead.parityErr | newHead.frameErr | newHead.brk);
    anySet     = strobes.overrun | (strobes.doPush & inErr) | newHeadErr;
  end

  always_ff @(posedge clk) begin
    if (strobes.doPush) mem[wrPtr] <= inEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.doClear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strobes.doPush) wrPtr <= wrPtr + 1'b1;
      if (strobes.doPop)  rdPtr <= nextRd;
      level <= level + CNTW'(strobes.doPush) - CNTW'(strobes.doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.doClear) begin
      ovrSticky <= 1'b0;
      peSticky  <= 1'b0;
      feSticky  <= 1'b0;
      biSticky  <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      ovrSticky <= (ovrSticky & ~strobes.doStatusRd) | strobes.overrun;
      peSticky  <= (peSticky & ~strobes.doStatusRd) | (headChange & newHead.parityErr);
      feSticky  <= (feSticky & ~strobes.doStatusRd) | (headChange & newHead.frameErr);
      biSticky  <= (biSticky & ~strobes.doStatusRd) | (headChange & newHead.brk);
      errSticky <= (errSticky & ~strobes.doStatusRd) | anySet;
    end
  end

  always_comb begin
    headData   = (level != '0) ? mem[rdPtr].data : '0;
    statusByte = {errSticky, txHoldEmpty & txShiftIdle, txHoldEmpty,
                  biSticky, feSticky, peSticky, ovrSticky, level != '0};
  end

  // R5
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0 && !strobes.doPush) |=> (level == '0));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doClear |=> (level == '0 && statusByte[4:0] == 5'b0 && !statusByte[7]));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.overrun |=> (ovrSticky && errSticky && level == FULL));

  // R2
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doStatusRd && !anySet && !strobes.doClear) |=> (statusByte[4:1] == 4'b0 && !statusByte[7]));

  // R10
  full_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (level == FULL && strobes.doPush && strobes.doPop) |=> (level == FULL));
endmodule

// File: rtl/line_status_unit.sv
module line_status_unit
  import lsr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushValid,
  input  logic [7:0] pushData,
  input  logic       pushParityErr,
  input  logic       pushFrameErr,
  input  logic       pushBreak,
  input  logic       popStrobe,
  input  logic       statusRead,
  input  logic       fifoClear,
  input  logic       txHoldEmpty,
  input  logic       txShiftIdle,
  output logic [7:0] statusByte,
  output logic [7:0] headData,
  output logic [4:0] fifoLevel
);
  localparam int DEPTH = 16;

  lsrStrobe_t strobes;
  rxEntry_t   inEntry;
  logic [4:0] level;

  assign inEntry = '{data: pushData, parityErr: pushParityErr,
                     frameErr: pushFrameErr, brk: pushBreak};

  lsr_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .pushValid (pushValid),
    .popStrobe (popStrobe),
    .statusRead(statusRead),
    .fifoClear (fifoClear),
    .level     (level),
    .strobes   (strobes)
  );

  lsr_datapath #(.DEPTH(DEPTH)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .inEntry    (inEntry),
    .txHoldEmpty(txHoldEmpty),
    .txShiftIdle(txShiftIdle),
    .level      (level),
    .statusByte (statusByte),
    .headData   (headData)
  );

  assign fifoLevel = level;
endmodule

// File: tb/sim_line_status_unit.sv
module sim_line_status_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pushValid = 0, pushParityErr = 0, pushFrameErr = 0, pushBreak = 0;
  logic [7:0] pushData = 0;
  logic       popStrobe = 0, statusRead = 0, fifoClear = 0;
  logic       txHoldEmpty = 1, txShiftIdle = 1;
  logic [7:0] statusByte, headData;
  logic [4:0] fifoLevel;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] expQ[$];

  always #10 clk = ~clk;

  line_status_unit u0 (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // one-cycle stimulus: drive at negedge, release and sample at next negedge
  task automatic step(bit push, logic [7:0] d, bit pe, bit fe, bit bi,
                      bit pop, bit rd, bit clr);
    @(negedge clk);
    pushValid = push; pushData = d; pushParityErr = pe; pushFrameErr = fe;
    pushBreak = bi; popStrobe = pop; statusRead = rd; fifoClear = clr;
    @(negedge clk);
    pushValid = 0; pushParityErr = 0; pushFrameErr = 0; pushBreak = 0;
    popStrobe = 0; statusRead = 0; fifoClear = 0;
  endtask

  // driver: pushes a character and records the expected byte
  task automatic pushChar(logic [7:0] d, bit pe, bit fe, bit bi);
    if (fifoLevel < 16) expQ.push_back(d);
    step(1, d, pe, fe, bi, 0, 0, 0);
  endtask

  // monitor: compares the head with the scoreboard, then pops
  task automatic popChar(string req);
    if (expQ.size() > 0) begin
      check(req, headData, expQ[0]);
      void'(expQ.pop_front());
    end
    step(0, 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic readStatus();
    step(0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x00 expected 0x01");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset status", statusByte, 8'h60);
    check("R1 reset level", {3'b0, fifoLevel}, 8'd0);
    check("R11 empty head", headData, 8'h00);

    // R1 clean character
    pushChar(8'h41, 0, 0, 0);
    check("R1 status", statusByte, 8'h61);
    check("R11 head", headData, 8'h41);

    // R7 flagged entry behind clean head only sets bit 7
    pushChar(8'h42, 1, 0, 0);
    check("R7 hidden parity", statusByte, 8'hE1);
    readStatus();
    check("R2 read clears", statusByte, 8'h61);
    popChar("R1 order");
    check("R7 parity at head", statusByte, 8'hE5);
    readStatus();
    check("R2 read clears parity", statusByte, 8'h61);
    popChar("R1 order");
    check("R1 empty again", statusByte, 8'h60);

    // R3 break
    pushChar(8'h00, 0, 0, 1);
    check("R3 break status", statusByte, 8'hF1);
    readStatus();
    check("R3 after read", statusByte, 8'h61);
    popChar("R3 zero byte");

    // framing error: 0xE9, sticky after pop (R2)
    pushChar(8'h63, 0, 1, 0);
    check("R2 framing status", statusByte, 8'hE9);
    pushChar(8'h62, 0, 0, 0);
    popChar("R2 framing byte");
    check("R2 sticky after pop", statusByte, 8'hE9);
    readStatus();
    check("R2 cleared", statusByte, 8'h61);
    popChar("R2 trailing byte");

    // R9 read and error in same cycle
    step(1, 8'h55, 0, 1, 0, 0, 1, 0);
    expQ.push_back(8'h55);
    check("R9 set wins", statusByte, 8'hE9);
    popChar("R9 byte");
    readStatus();
    check("R9 cleared", statusByte, 8'h60);

    // R4 overrun
    for (int i = 0; i < 16; i++) pushChar(8'h30 + 8'(i), 0, 0, 0);
    check("R4 full level", {3'b0, fifoLevel}, 8'd16);
    pushChar(8'h78, 0, 0, 0);
    check("R4 overrun status", statusByte, 8'hE3);
    check("R4 level held", {3'b0, fifoLevel}, 8'd16);
    readStatus();
    check("R4 after read", statusByte, 8'h61);

    // R10 push and pop together at full
    expQ.push_back(8'h99);
    check("R10 head before", headData, expQ[0]);
    void'(expQ.pop_front());
    step(1, 8'h99, 0, 0, 0, 1, 0, 0);
    check("R10 level", {3'b0, fifoLevel}, 8'd16);
    check("R10 no overrun", statusByte, 8'h61);
    for (int i = 0; i < 16; i++) popChar("R4 order");
    check("R4 drained", {3'b0, fifoLevel}, 8'd0);

    // R5 pop on empty
    popChar("R5");
    check("R5 level", {3'b0, fifoLevel}, 8'd0);
    check("R5 status", statusByte, 8'h60);

    // R6 clear
    pushChar(8'h11, 0, 1, 0);
    pushChar(8'h12, 0, 0, 0);
    step(1, 8'h13, 0, 0, 0, 0, 0, 1);
    expQ.delete();
    check("R6 status", statusByte, 8'h60);
    check("R6 level", {3'b0, fifoLevel}, 8'd0);
    check("R11 cleared head", headData, 8'h00);

    // R8 transmit bits
    @(negedge clk); txShiftIdle = 0;
    #1 check("R8 shifter busy", statusByte, 8'h20);
    txHoldEmpty = 0;
    #1 check("R8 holding full", statusByte, 8'h00);
    txHoldEmpty = 1; txShiftIdle = 1;
    #1 check("R8 idle", statusByte, 8'h60);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule